// File: doc/BRIEF.md
# Embedded Core Test Wrapper

This block surrounds an embedded core and decides, terminal by terminal, whether the core talks to the rest of the chip directly or through a scan-style boundary chain. In normal operation every wrapper path is plain wiring: chip-side inputs reach the core inputs, and core outputs reach the chip. For testing, a mode register selects one of two test views. In the internal view the boundary cells feed stimulus into the core and catch its responses. In the external view the boundary cells drive the chip-side outputs and sample the chip-side inputs, so the logic around the core can be tested.

Test data moves serially. It enters on a single serial input and leaves on a single serial output. Shift, capture and update strobes control the movement. A one-bit bypass stage can take the place of the whole boundary chain, which shortens the serial path to one flip-flop when this core is not under test. Each boundary cell has one flip-flop and two 2:1 multiplexers. One multiplexer chooses what the flip-flop loads. The other chooses what the terminal sees.

Top module: `core_wrapper`

## Requirements
- R1: An active-low asynchronous reset clears every boundary cell and the bypass flip-flop, and sets the active mode to functional. While reset is held and the bypass is not selected, serial_o is 0.
- R2: In functional mode, core_in_o equals func_in_i and func_out_o equals core_out_i in the same cycle, with no register in the path.
- R3: On a rising clock edge with update_i high, the active mode loads mode_i. Code 2'b00 selects functional, 2'b01 selects internal test, 2'b10 selects external test, and 2'b11 is treated as functional. With update_i low, the active mode holds.
- R4: In internal-test mode, core_in_o[k] is the flip-flop of input cell k, and func_out_o still follows core_out_i.
- R5: In external-test mode, func_out_o[j] is the flip-flop of output cell j, and core_in_o still follows func_in_i.
- R6: With the chain selected and shift_i high, every cell takes the value of its predecessor on the rising edge. Input cell 0 takes serial_i. The order runs through input cells 0 to N_IN-1 and then output cells 0 to N_OUT-1. serial_o shows the last output cell.
- R7: With the chain selected, capture_i high and shift_i low, each input cell loads its func_in_i bit and each output cell loads its core_out_i bit, whatever the mode.
- R8: When shift_i and capture_i are both high, the shift is performed and the capture is dropped.
- R9: With the chain selected and neither shift_i nor capture_i high, every cell keeps its value.
- R10: With sel_bypass_i high, shift_i loads serial_i into the bypass flip-flop, and serial_o shows that flip-flop combinationally. Shift and capture leave the boundary chain unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test and mode clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Requested mode code, loaded by update_i |
| update_i | input | 1 | Loads mode_i into the active mode |
| shift_i | input | 1 | Serial shift strobe |
| capture_i | input | 1 | Parallel capture strobe |
| sel_bypass_i | input | 1 | 1 selects the bypass stage, 0 selects the boundary chain |
| serial_i | input | 1 | Serial test data in |
| serial_o | output | 1 | Serial test data out |
| func_in_i | input | N_IN | Chip-side values headed for the core |
| core_in_o | output | N_IN | Values applied to the core inputs |
| core_out_i | input | N_OUT | Values from the core outputs |
| func_out_o | output | N_OUT | Values handed to the chip side |

## Verification
Shift and capture can both be asserted on the same edge. The random stimulus raises them together in about one cycle in eight, often while new values are waiting on func_in_i and core_out_i. The reference model applies only the shift in those cycles, so a design that lets capture win, or merges the two, sends a wrong bit to serial_o within at most the chain length of later shifts. A mode update can land in the same cycle as a shift or capture. The terminal outputs checked just after that edge confirm that the new mode and the new cell contents took effect together.

// File: rtl/wrap_pkg.sv
package wrap_pkg;
  typedef enum logic [1:0] {
    WM_FUNC   = 2'b00,
    WM_INTEST = 2'b01,
    WM_EXTEST = 2'b10
  } wrap_mode_e;
endpackage

// File: rtl/wrap_mode_dec.sv
module wrap_mode_dec
  import wrap_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       update_i,
  input  logic [1:0] mode_i,
  output wrap_mode_e mode_o
);
  wrap_mode_e mode_d, mode_q;

  always_comb begin
    unique case (mode_i)
      2'b01:   mode_d = WM_INTEST;
      2'b10:   mode_d = WM_EXTEST;
      default: mode_d = WM_FUNC;  // 2'b11 folds onto functional
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mode_q <= WM_FUNC;
    else if (update_i) mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  AST_MODE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> (mode_q == (($past(mode_i) == 2'b01) ? WM_INTEST :
                             ($past(mode_i) == 2'b10) ? WM_EXTEST : WM_FUNC))); // R3
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(mode_q)); // R3
endmodule

// File: rtl/wrap_bcell.sv
module wrap_bcell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_en_i,
  input  logic capt_en_i,
  input  logic si_i,
  input  logic cap_d_i,
  input  logic func_d_i,
  input  logic drive_test_i,
  output logic q_o,
  output logic term_o
);
  logic q_q;
  logic load_d;

  // mux 1: load source; shift has priority over capture
  assign load_d = shift_en_i ? si_i : cap_d_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      q_q <= 1'b0;
    else if (shift_en_i || capt_en_i) q_q <= load_d;
  end

  // mux 2: terminal source
  assign term_o = drive_test_i ? q_q : func_d_i;
  assign q_o    = q_q;

  AST_CELL_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> (q_q == $past(si_i))); // R6
  AST_CELL_SHIFT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_en_i && capt_en_i) |=> (q_q == $past(si_i))); // R8
  AST_CELL_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capt_en_i && !shift_en_i) |=> (q_q == $past(cap_d_i))); // R7
  AST_CELL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_en_i && !capt_en_i) |=> $stable(q_q)); // R9
endmodule

// File: rtl/wrap_bypass.sv
module wrap_bypass (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_en_i,
  input  logic si_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         q_q <= 1'b0;
    else if (shift_en_i) q_q <= si_i;
  end

  assign q_o = q_q;

  AST_BYP_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> (q_q == $past(si_i))); // R10
  AST_BYP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(q_q)); // R10
endmodule

// File: rtl/core_wrapper.sv
module core_wrapper
  import wrap_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             update_i,
  input  logic             shift_i,
  input  logic             capture_i,
  input  logic             sel_bypass_i,
  input  logic             serial_i,
  output logic             serial_o,
  input  logic [N_IN-1:0]  func_in_i,
  output logic [N_IN-1:0]  core_in_o,
  input  logic [N_OUT-1:0] core_out_i,
  output logic [N_OUT-1:0] func_out_o
);
  localparam int N_TOT = N_IN + N_OUT;

  wrap_mode_e       mode_q;
  logic             drive_in, drive_out;
  logic             chain_shift, chain_capt, byp_shift;
  logic [N_TOT-1:0] chain_q;
  logic [N_TOT-1:0] chain_in;
  logic             byp_q;

  wrap_mode_dec u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .update_i (update_i),
    .mode_i   (mode_i),
    .mode_o   (mode_q)
  );

  assign drive_in    = (mode_q == WM_INTEST);
  assign drive_out   = (mode_q == WM_EXTEST);
  assign chain_shift = shift_i   && !sel_bypass_i;
  assign chain_capt  = capture_i && !sel_bypass_i;
  assign byp_shift   = shift_i   &&  sel_bypass_i;
  assign chain_in    = {chain_q[N_TOT-2:0], serial_i};

  for (genvar k = 0; k < N_IN; k++) begin : g_in_cell
    wrap_bcell u_cell (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .shift_en_i   (chain_shift),
      .capt_en_i    (chain_capt),
      .si_i         (chain_in[k]),
      .cap_d_i      (func_in_i[k]),
      .func_d_i     (func_in_i[k]),
      .drive_test_i (drive_in),
      .q_o          (chain_q[k]),
      .term_o       (core_in_o[k])
    );
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out_cell
    wrap_bcell u_cell (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .shift_en_i   (chain_shift),
      .capt_en_i    (chain_capt),
      .si_i         (chain_in[N_IN+j]),
      .cap_d_i      (core_out_i[j]),
      .func_d_i     (core_out_i[j]),
      .drive_test_i (drive_out),
      .q_o          (chain_q[N_IN+j]),
      .term_o       (func_out_o[j])
    );
  end

  wrap_bypass u_bypass (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (byp_shift),
    .si_i       (serial_i),
    .q_o        (byp_q)
  );

  assign serial_o = sel_bypass_i ? byp_q : chain_q[N_TOT-1];

  AST_CHAIN_FROZEN_IN_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_bypass_i |=> $stable(chain_q)); // R10
  AST_TRANSPARENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == WM_FUNC) |-> (core_in_o == func_in_i && func_out_o == core_out_i)); // R2
  AST_CHAIN_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_shift |=> (chain_q == {$past(chain_q[N_TOT-2:0]), $past(serial_i)})); // R6
endmodule

// File: tb/tb_core_wrapper.sv
`timescale 1ns/1ps
module tb_core_wrapper;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int NT = NI + NO;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = '0;
  logic upd = 0, sh = 0, cap = 0, byp = 0, si = 0;
  logic [NI-1:0] fin = '0;
  logic [NO-1:0] cout = '0;
  logic [NI-1:0] cin;
  logic [NO-1:0] fout;
  logic so;

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  bit ch[NT];
  int m = 0;
  bit bq = 0;
  string op = "R1";
  string mtag = "";

  always #2.5 clk = ~clk;

  core_wrapper #(.N_IN(NI), .N_OUT(NO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .update_i(upd),
    .shift_i(sh), .capture_i(cap), .sel_bypass_i(byp), .serial_i(si),
    .serial_o(so), .func_in_i(fin), .core_in_o(cin),
    .core_out_i(cout), .func_out_o(fout)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (ch[i]) ch[i] = 0;
      m = 0; bq = 0; op = "R1"; mtag = "";
    end else begin
      mtag = upd ? "R3 " : "";
      if (upd) m = (mode == 2'b01) ? 1 : (mode == 2'b10) ? 2 : 0;
      if (byp) begin
        op = "R10";
        if (sh) bq = si;
      end else if (sh) begin
        op = cap ? "R8" : "R6";
        for (int i = NT - 1; i > 0; i--) ch[i] = ch[i-1];
        ch[0] = si;
      end else if (cap) begin
        op = "R7";
        for (int i = 0; i < NI; i++) ch[i] = fin[i];
        for (int j = 0; j < NO; j++) ch[NI+j] = cout[j];
      end else begin
        op = "R9";
      end
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic [7:0] e_cin, e_fout;
    logic e_so;
    #1;
    e_cin = '0; e_fout = '0;
    for (int i = 0; i < NI; i++) e_cin[i] = (m == 1) ? ch[i] : fin[i];
    for (int j = 0; j < NO; j++) e_fout[j] = (m == 2) ? ch[NI+j] : cout[j];
    e_so = byp ? bq : ch[NT-1];
    if (!rst_n) begin
      chk("R1 core_in", 8'(cin), e_cin);
      chk("R1 func_out", 8'(fout), e_fout);
      chk("R1 serial_o", 8'(so), 8'(e_so));
    end else begin
      chk({mtag, (m == 1) ? "R4" : "R2", " core_in"}, 8'(cin), e_cin);
      chk({mtag, (m == 2) ? "R5" : "R2", " func_out"}, 8'(fout), e_fout);
      chk({op, " serial_o"}, 8'(so), 8'(e_so));
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 1600; c++) begin
      @(negedge clk);
      if (c == 800) rst_n = 1'b0;
      else rst_n = 1'b1;
      mode = 2'($urandom);
      upd  = ($urandom % 8) == 0;
      sh   = ($urandom % 2) == 0;
      cap  = ($urandom % 4) == 0;
      byp  = ($urandom % 6) == 0;
      si   = 1'($urandom);
      fin  = NI'($urandom);
      cout = NO'($urandom);
    end
    @(negedge clk);
    summary();
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 act=hung exp=done");
    summary();
  end
endmodule